// File: doc/BRIEF.md
# GPIO Bank with Sticky Edge Capture

This block is a bank of ten general-purpose pins behind a byte-wide register bus. Each pin has its own direction, input mode, edge select, interrupt enable and interrupt status bit. A pin set as an output drives the value of its data bit. A pin set as an input is brought through a two-flop synchronizer. Its data bit then either follows the synchronized level, or latches chosen transitions as a sticky event flag that software clears by writing zero. A separate status bit records interrupt edges and is cleared by writing one. One interrupt line is raised while any enabled status bit is set.

The register bus is a plain strobe bus with no back-pressure. A write is taken on the rising clock edge where `bus_we` is high. A read returns the byte at `bus_addr` combinationally on `bus_rdata` in the same cycle. Every register is 16 bits wide and takes two consecutive byte addresses, low byte first. Pin n sits at bit n+1 of every register. Bit 0 and bits 15 to 11 are reserved. Reserved bits read as zero and ignore writes. There is no streamed data in or out of the block, so no interface has valid/ready.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0x00 at all of its byte addresses, `gpio_oe` and `gpio_o` are all zero and `irq` is low.
- R2: The registers sit at these byte addresses, low byte first: direction 0x20/0x21, data 0x22/0x23, input mode 0x24/0x25, edge select 0x26/0x27, interrupt enable 0x28/0x29, interrupt status 0x2A/0x2B. Pin n is at bit n+1 of the 16-bit word. Reserved bits and addresses outside 0x20 to 0x2B read as 0x00, and writes to them are ignored. A written register value can be read back in the next cycle.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. `gpio_oe[n]` equals the direction bit. An output pin drives its data bit on `gpio_o[n]`, and register writes set that data bit. An input pin drives 0 on `gpio_o[n]`.
- R4: An input-mode bit of 0 selects level mode. In level mode the data bit reads the pin level three rising clock edges after the pin changes, and register writes to the data bit have no effect.
- R5: An input-mode bit of 1 selects edge mode. In edge mode the data bit becomes 1 on a rising transition when edge select is 0, and on either transition when edge select is 1. It then holds 1 until a 0 is written to it. Writing 1 to it has no effect. It becomes 1 three rising clock edges after the pin changes.
- R6: In either input mode, the interrupt status bit of an input pin becomes 1 on a rising transition when edge select is 0, and on a falling transition when edge select is 1, three edges after the pin changes. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: When a transition sets an edge-mode data bit or a status bit on the same clock edge where a register write clears it, the bit ends up as 1.
- R8: `irq` is high exactly when some pin has both its status bit and its enable bit set. It changes in the cycle after the write or status update that causes the change.
- R9: While a pin is an output, transitions on its input set neither its status bit nor its data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 8 | Byte address for the read or write |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for `bus_addr`, combinational |
| gpio_i | input | 10 | Asynchronous pin input levels |
| gpio_o | output | 10 | Pin output values |
| gpio_oe | output | 10 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A pin change applied between two rising edges shows up in the data bit, the status bit and `irq` after the third rising edge that follows it. The first edge fills the first synchronizer flop, the second fills the second, and the third updates the register. The directed checks read one low phase before that third edge, where the old value must still be present, and one low phase after it, where the new value is due. A register write takes effect on the edge where the strobe is high, and reads are combinational, so readback and `irq` are checked one nanosecond after the falling edge that follows. The random phase keeps a cycle-level model of the same rules, updated on the same rising edges. Each falling edge compares `bus_rdata`, `gpio_o`, `gpio_oe` and `irq` with that model.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  // Register index as seen by the decoder; order sets the address map.
  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_DAT  = 3'd1,
    SEL_MODE = 3'd2,
    SEL_ESEL = 3'd3,
    SEL_IEN  = 3'd4,
    SEL_IST  = 3'd5,
    SEL_NONE = 3'd7
  } reg_sel_e;

  localparam int NUM_REGS = 6;
  localparam int REG_W    = 16;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_decode.sv
`timescale 1ns/1ps
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int          AW   = 8,
  parameter logic [AW-1:0] BASE = 8'h20
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel,
  output logic          hi
);
  logic [AW-1:0] off;
  logic [AW-2:0] idx;

  assign off = addr - BASE;
  assign idx = off[AW-1:1];
  assign hi  = off[0];

  always_comb begin
    if (off < AW'(2 * NUM_REGS)) sel = reg_sel_e'(idx[2:0]);
    else                         sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_pin.sv
`timescale 1ns/1ps
module gpio_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,      // synchronized pin level
  input  logic wbit,     // bus data bit for this pin
  input  logic we_dir,
  input  logic we_dat,
  input  logic we_mode,
  input  logic we_esel,
  input  logic we_ien,
  input  logic we_ist,
  output logic dir,
  output logic dat,
  output logic mode,
  output logic esel,
  output logic ien,
  output logic ist
);
  logic prev;
  logic rise, fall, cap, iev;

  // Edges only count while the pin is an input.
  assign rise = ~dir & lvl & ~prev;
  assign fall = ~dir & ~lvl & prev;
  assign cap  = rise | (esel & fall);
  assign iev  = esel ? fall : rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      dir  <= 1'b0;
      dat  <= 1'b0;
      mode <= 1'b0;
      esel <= 1'b0;
      ien  <= 1'b0;
      ist  <= 1'b0;
    end else begin
      prev <= lvl;
      if (we_dir)  dir  <= wbit;
      if (we_mode) mode <= wbit;
      if (we_esel) esel <= wbit;
      if (we_ien)  ien  <= wbit;

      if (dir) begin
        if (we_dat) dat <= wbit;
      end else if (!mode) begin
        dat <= lvl;
      end else if (cap) begin
        dat <= 1'b1;                  // event beats a same-cycle clear
      end else if (we_dat && !wbit) begin
        dat <= 1'b0;
      end

      if (iev)                 ist <= 1'b1;
      else if (we_ist && wbit) ist <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int            NPINS     = 10,
  parameter int            FIRST_BIT = 1,
  parameter int            AW        = 8,
  parameter logic [AW-1:0] BASE      = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [NPINS-1:0] gpio_i,
  output logic [NPINS-1:0] gpio_o,
  output logic [NPINS-1:0] gpio_oe,
  output logic             irq
);
  localparam int PAD = REG_W - NPINS;

  reg_sel_e         sel;
  logic             hi;
  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] dir_q, dat_q, mode_q, esel_q, ien_q, ist_q;
  logic [NPINS-1:0] rd_vec;
  logic [REG_W-1:0] rd_word;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_i), .q(lvl)
  );

  gpio_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .addr(bus_addr), .sel(sel), .hi(hi)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int POS  = i + FIRST_BIT;
    localparam int LANE = POS / 8;
    localparam int BITX = POS % 8;
    logic hit;
    assign hit = bus_we && (hi == LANE[0]);

    gpio_pin u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl[i]),
      .wbit   (bus_wdata[BITX]),
      .we_dir (hit && sel == SEL_DIR),
      .we_dat (hit && sel == SEL_DAT),
      .we_mode(hit && sel == SEL_MODE),
      .we_esel(hit && sel == SEL_ESEL),
      .we_ien (hit && sel == SEL_IEN),
      .we_ist (hit && sel == SEL_IST),
      .dir    (dir_q[i]),
      .dat    (dat_q[i]),
      .mode   (mode_q[i]),
      .esel   (esel_q[i]),
      .ien    (ien_q[i]),
      .ist    (ist_q[i])
    );
  end

  always_comb begin
    case (sel)
      SEL_DIR:  rd_vec = dir_q;
      SEL_DAT:  rd_vec = dat_q;
      SEL_MODE: rd_vec = mode_q;
      SEL_ESEL: rd_vec = esel_q;
      SEL_IEN:  rd_vec = ien_q;
      SEL_IST:  rd_vec = ist_q;
      default:  rd_vec = '0;
    endcase
  end

  assign rd_word   = {{PAD{1'b0}}, rd_vec} << FIRST_BIT;
  assign bus_rdata = hi ? rd_word[15:8] : rd_word[7:0];

  assign gpio_oe = dir_q;
  assign gpio_o  = dat_q & dir_q;
  assign irq     = |(ist_q & ien_q);
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk #(
  parameter int NPINS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [NPINS-1:0] gpio_o,
  input logic [NPINS-1:0] gpio_oe,
  input logic             irq,
  input logic [NPINS-1:0] dat,
  input logic [NPINS-1:0] mode,
  input logic [NPINS-1:0] ien,
  input logic [NPINS-1:0] ist
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(gpio_oe) && $stable(gpio_o & gpio_oe))); // R3

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ((dat & $past(mode & ~gpio_oe & dat)) == $past(mode & ~gpio_oe & dat))); // R5

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ((ist & $past(ist)) == $past(ist))); // R6

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ist != '0) && (ien != '0))); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq); // R8

  AST_NO_OUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ist & ~$past(ist) & $past(gpio_oe)) == '0)); // R9
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .gpio_o(gpio_o),
  .gpio_oe(gpio_oe), .irq(irq), .dat(dat_q), .mode(mode_q),
  .ien(ien_q), .ist(ist_q)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  localparam int CLK_NS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [9:0] gpio_i = '0;
  logic [9:0] gpio_o, gpio_oe;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_i(gpio_i),
    .gpio_o(gpio_o), .gpio_oe(gpio_oe), .irq(irq)
  );

  // ---------------- reference model (from the requirements) ----------------
  logic [9:0] m_dir, m_dat, m_mode, m_esel, m_ien, m_ist, m_s1, m_s2, m_pv;

  function automatic logic [9:0] lane_mask(input logic hi);
    logic [15:0] w = hi ? 16'hFF00 : 16'h00FF;
    return w[10:1];
  endfunction

  function automatic logic [9:0] lane_val(input logic hi, input logic [7:0] d);
    logic [15:0] w = hi ? {d, 8'h00} : {8'h00, d};
    return w[10:1];
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    logic [9:0] v;
    logic [15:0] w;
    if (a < 8'h20 || a > 8'h2B) return 8'h00;
    case ((a - 8'h20) >> 1)
      0: v = m_dir;  1: v = m_dat;  2: v = m_mode;
      3: v = m_esel; 4: v = m_ien;  default: v = m_ist;
    endcase
    w = {5'b0, v, 1'b0};
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  logic [9:0] t_rise, t_fall, t_cap, t_iev, t_m, t_v;
  logic [9:0] w_dir, w_dat, w_mode, w_esel, w_ien, w_ist;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir <= '0; m_dat <= '0; m_mode <= '0; m_esel <= '0;
      m_ien <= '0; m_ist <= '0; m_s1 <= '0; m_s2 <= '0; m_pv <= '0;
    end else begin
      t_rise = m_s2 & ~m_pv & ~m_dir;
      t_fall = ~m_s2 & m_pv & ~m_dir;
      t_cap  = t_rise | (m_esel & t_fall);
      t_iev  = (~m_esel & t_rise) | (m_esel & t_fall);
      t_m    = lane_mask(bus_addr[0]);
      t_v    = lane_val(bus_addr[0], bus_wdata);
      w_dir  = (bus_we && bus_addr[7:1] == 7'h10) ? t_m : '0;
      w_dat  = (bus_we && bus_addr[7:1] == 7'h11) ? t_m : '0;
      w_mode = (bus_we && bus_addr[7:1] == 7'h12) ? t_m : '0;
      w_esel = (bus_we && bus_addr[7:1] == 7'h13) ? t_m : '0;
      w_ien  = (bus_we && bus_addr[7:1] == 7'h14) ? t_m : '0;
      w_ist  = (bus_we && bus_addr[7:1] == 7'h15) ? t_m : '0;
      m_s1 <= gpio_i;
      m_s2 <= m_s1;
      m_pv <= m_s2;
      m_dir  <= (w_dir & t_v)  | (~w_dir & m_dir);
      m_mode <= (w_mode & t_v) | (~w_mode & m_mode);
      m_esel <= (w_esel & t_v) | (~w_esel & m_esel);
      m_ien  <= (w_ien & t_v)  | (~w_ien & m_ien);
      m_dat  <= (m_dir & ((w_dat & t_v) | (~w_dat & m_dat)))
              | (~m_dir & ~m_mode & m_s2)
              | (~m_dir & m_mode & (t_cap | (m_dat & ~(w_dat & ~t_v))));
      m_ist  <= t_iev | (m_ist & ~(w_ist & t_v));
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1 chk(tag, {8'h00, bus_rdata}, {8'h00, exp});
  endtask

  task automatic set_pin(input int k, input logic v);
    @(negedge clk);
    gpio_i[k] = v;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog R1..: run did not complete");
    summary();
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 8'h1E; a <= 8'h2D; a++) rd(8'(a), 8'h00, "R1 reset read");
    chk("R1 gpio_oe", {6'b0, gpio_oe}, 16'h0);
    chk("R1 gpio_o", {6'b0, gpio_o}, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R2 / R3: map, reserved bits, output drive
    wr(8'h20, 8'hFF); wr(8'h21, 8'hFF);
    rd(8'h20, 8'hFE, "R2 dir low reserved bit0");
    rd(8'h21, 8'h07, "R2 dir high reserved bits");
    wr(8'h22, 8'hAA);
    rd(8'h22, 8'hAA, "R3 data readback");
    chk("R3 gpio_o low lane", {6'b0, gpio_o}, 16'h055);
    wr(8'h23, 8'h05);
    rd(8'h23, 8'h05, "R3 data high readback");
    chk("R3 gpio_o both lanes", {6'b0, gpio_o}, 16'h2D5);
    chk("R3 gpio_oe", {6'b0, gpio_oe}, 16'h3FF);
    wr(8'h2E, 8'hFF);
    rd(8'h2E, 8'h00, "R2 unmapped address");
    wr(8'h20, 8'h00); wr(8'h21, 8'h00);
    rd(8'h22, 8'h00, "R4 input follows low pin");
    chk("R3 input drives zero", {6'b0, gpio_o}, 16'h0);

    // R4 / R6 / R8: level mode, rising status, enable, W1C
    set_pin(0, 1'b1);
    @(negedge clk);
    rd(8'h22, 8'h00, "R4 before third edge");
    rd(8'h22, 8'h02, "R4 after third edge");
    rd(8'h2A, 8'h02, "R6 rising sets status");
    wr(8'h22, 8'h00);
    rd(8'h22, 8'h02, "R4 write ignored");
    chk("R8 irq masked", {15'b0, irq}, 16'h0);
    wr(8'h28, 8'h02);
    chk("R8 irq enabled", {15'b0, irq}, 16'h1);
    wr(8'h2A, 8'h00);
    rd(8'h2A, 8'h02, "R6 zero write keeps status");
    wr(8'h2A, 8'h02);
    rd(8'h2A, 8'h00, "R6 one write clears");
    chk("R8 irq drops", {15'b0, irq}, 16'h0);
    set_pin(0, 1'b0);
    repeat (4) @(negedge clk);
    rd(8'h2A, 8'h00, "R6 falling ignored with select 0");
    rd(8'h22, 8'h00, "R4 follows pin low");

    // R5: edge mode, both edges, on pin 1 (bit 2)
    wr(8'h24, 8'h04); wr(8'h26, 8'h04);
    set_pin(1, 1'b1);
    @(negedge clk); @(negedge clk);
    rd(8'h22, 8'h04, "R5 rising capture");
    rd(8'h2A, 8'h00, "R6 rising ignored with select 1");
    set_pin(1, 1'b0);
    repeat (3) @(negedge clk);
    rd(8'h2A, 8'h04, "R6 falling sets status");
    chk("R8 irq pin1 not enabled", {15'b0, irq}, 16'h0);
    rd(8'h22, 8'h04, "R5 sticky after pin low");
    wr(8'h22, 8'h00);
    rd(8'h22, 8'h00, "R5 zero write clears");
    wr(8'h22, 8'h04);
    rd(8'h22, 8'h00, "R5 one write ignored");
    wr(8'h2A, 8'h04);

    // R7: set beats clear on the same edge
    set_pin(1, 1'b1);
    @(negedge clk);
    wr(8'h22, 8'h00);
    rd(8'h22, 8'h04, "R7 data set wins");
    set_pin(1, 1'b0);
    @(negedge clk);
    wr(8'h2A, 8'h04);
    rd(8'h2A, 8'h04, "R7 status set wins");
    wr(8'h2A, 8'h04); wr(8'h22, 8'h00);

    // R9: output pin 2 (bit 3) ignores its input
    wr(8'h20, 8'h08);
    for (int t = 0; t < 4; t++) begin
      set_pin(2, ~t[0]);
      repeat (3) @(negedge clk);
    end
    rd(8'h2A, 8'h00, "R9 no status on output");
    rd(8'h22, 8'h00, "R9 data unchanged on output");
    wr(8'h20, 8'h00);

    // Random phase against the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) gpio_i[$urandom_range(0, 9)] ^= 1'b1;
      bus_we    = ($urandom_range(0, 3) == 0);
      bus_addr  = 8'($urandom_range(8'h1E, 8'h2D));
      bus_wdata = 8'($urandom);
      #1;
      if (!bus_we) chk("R2 random read", {8'h00, bus_rdata}, {8'h00, exp_read(bus_addr)});
      chk("R3 random gpio_o", {6'b0, gpio_o}, {6'b0, m_dat & m_dir});
      chk("R3 random gpio_oe", {6'b0, gpio_oe}, {6'b0, m_dir});
      chk("R8 random irq", {15'b0, irq}, {15'b0, |(m_ist & m_ien)});
    end
    @(negedge clk);
    bus_we = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule